// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. It runs on a clock at sixteen times the bit rate. When the idle line is first seen low on a rising clock edge, a phase counter starts. The line is then read on the falling clock edge seven and a half clock periods later, which is the middle of the start bit. Every following bit is read sixteen periods after the one before. A start bit that has gone high again by its middle is treated as a glitch and dropped.

Word length, parity enable and parity sense come from control inputs. They are captured when a start edge is accepted, so a change during a character does not disturb that character. At the middle of the first stop bit the block does four things:
- it presents the character on a parallel bus;
- it raises a ready flag;
- it updates the framing, parity and overrun flags;
- it goes straight back to watching for the next start edge.

The host lowers the ready flag with a one-cycle acknowledge pulse.

Top module: `serial_rx16`

## Requirements
- R1: After reset, `rx_ready`, `frame_err`, `par_err` and `overrun` are 0 and `rx_data` is 0.
- R2: A character is 1 start bit (low), then the data bits least significant first, then a parity bit if enabled, then a stop bit (high). Each bit lasts 16 clock periods. The line is sampled 7.5 clock periods after the rising edge that first sees it low, and every 16 periods after that.
- R3: If the line is high again when the start bit is sampled, the receiver returns to idle and produces no character.
- R4: `word_len` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. The data is right-aligned on `rx_data`, and the unused upper bits read 0.
- R5: When `par_en` is 1, a parity bit follows the data. `par_odd` = 0 selects even parity and 1 selects odd parity. `par_err` is set for a mismatch and cleared for a good character. When `par_en` is 0, no parity bit is expected and `par_err` is 0.
- R6: `frame_err` takes the inverse of the line value sampled at the middle of the first stop bit. The character is delivered either way.
- R7: `rx_ready` and all the status flags update on the rising edge that follows the middle of the stop bit. Half a cycle earlier, `rx_ready` is still 0.
- R8: A pulse on `ack` clears `rx_ready` on the next rising edge. A character that completes in the same cycle takes precedence.
- R9: When a character completes, `overrun` takes the value `rx_ready` had at that moment. The new character replaces the held data.
- R10: The search for the next start edge begins at the middle of the first stop bit. A stop bit shortened to 9 clock periods, followed at once by a new start bit, is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, 16x bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd, 0 = even parity |
| ack | input | 1 | Clears rx_ready |
| rx_data | output | 8 | Last received character |
| rx_ready | output | 1 | Character available |
| frame_err | output | 1 | Stop bit read low |
| par_err | output | 1 | Parity mismatch |
| overrun | output | 1 | Character arrived while rx_ready was set |

## Verification
Random characters are sent with random word length, parity mode, deliberately corrupted parity bits and bad stop bits. This separates data assembly and bit order from errors in parity sense and in framing. Directed frames cover the following:
- a runt start pulse, which must not produce a character;
- ready timing to the half cycle at the stop middle;
- two characters with no acknowledge, which tells overrun apart from plain replacement;
- back-to-back frames with a 9-period stop bit, which only work if the start search resumes at the stop middle.

// File: rtl/serial_rx16.sv
`timescale 1ns/1ps
module serial_rx16 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       ack,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       frame_err,
  output logic       par_err,
  output logic       overrun
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;
  st_t st;

  logic       rx_half;
  logic [3:0] phase;
  logic [2:0] nbit;
  logic [7:0] shreg;
  logic [1:0] len_q;
  logic       pen_q, podd_q, pbit;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) rx_half <= 1'b1;
    else        rx_half <= rxd;

  wire       tick     = (phase == 4'd7);
  wire       last_bit = (nbit == {1'b1, len_q});
  wire       done     = (st == S_STOP) && tick;
  wire [7:0] aligned  = shreg >> (2'd3 - len_q);
  wire       par_bad  = pen_q & (^aligned ^ pbit ^ podd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; phase <= '0; nbit <= '0; shreg <= '0;
      len_q <= '0; pen_q <= 1'b0; podd_q <= 1'b0; pbit <= 1'b0;
    end else begin
      phase <= phase + 4'd1;
      unique case (st)
        S_IDLE: if (!rxd) begin
          st <= S_START; phase <= '0;
          len_q <= word_len; pen_q <= par_en; podd_q <= par_odd;
        end
        S_START: if (tick) begin
          if (rx_half) st <= S_IDLE;
          else begin st <= S_DATA; nbit <= '0; end
        end
        S_DATA: if (tick) begin
          shreg <= {rx_half, shreg[7:1]};
          nbit  <= nbit + 3'd1;
          if (last_bit) st <= pen_q ? S_PAR : S_STOP;
        end
        S_PAR: if (tick) begin
          pbit <= rx_half; st <= S_STOP;
        end
        S_STOP: if (tick) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rx_ready <= 1'b0; frame_err <= 1'b0;
      par_err <= 1'b0; overrun <= 1'b0;
    end else if (done) begin
      rx_data   <= aligned;
      rx_ready  <= 1'b1;
      frame_err <= ~rx_half;
      par_err   <= par_bad;
      overrun   <= rx_ready;
    end else if (ack) begin
      rx_ready <= 1'b0;
    end
  end

  a_r7_ready_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_ready);
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !done) |=> !rx_ready);
  a_r3_runt_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && tick && rx_half) |=> (st == S_IDLE && $stable(rx_ready)));
  a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_ready) |=> overrun);
  a_r5_no_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pen_q) |=> !par_err);
  a_r7_ready_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(st) == S_STOP);
endmodule

// File: tb/tb_serial_rx16.sv
`timescale 1ns/1ps
module tb_serial_rx16;
  logic clk = 0, rst_n = 0, rxd = 1, par_en = 0, par_odd = 0, ack = 0;
  logic [1:0] word_len = 2'd3;
  logic [7:0] rx_data;
  logic rx_ready, frame_err, par_err, overrun;
  int tests = 0, fails = 0;
  bit ready_m = 0;
  bit finished = 0;

  serial_rx16 dut (.clk, .rst_n, .rxd, .word_len, .par_en, .par_odd, .ack,
                   .rx_data, .rx_ready, .frame_err, .par_err, .overrun);

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_of(input logic [1:0] len);
    return 8'hFF >> (3 - len);
  endfunction

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] len, input bit pe,
                      input bit po, input bit stop_ok, input bit corrupt, input int stop_len);
    logic [7:0] md;
    logic pbit;
    md = d & mask_of(len);
    pbit = ^md ^ po ^ corrupt;
    @(negedge clk);
    word_len = len; par_en = pe; par_odd = po;
    rxd = 0; wait_neg(16);
    for (int i = 0; i < 5 + len; i++) begin rxd = md[i]; wait_neg(16); end
    if (pe) begin rxd = pbit; wait_neg(16); end
    rxd = stop_ok;
    wait_neg(8);
    if (!ready_m) check("R7 ready not yet at stop middle", rx_ready, 0);
    wait_neg(1);
    rxd = 1;
    check("R7 ready after stop middle", rx_ready, 1);
    check("R2 R4 data", rx_data, md);
    check("R5 parity flag", par_err, pe & corrupt);
    check("R6 framing flag", frame_err, !stop_ok);
    check("R9 overrun flag", overrun, ready_m);
    ready_m = 1;
    if (stop_len > 9) wait_neg(stop_len - 9);
  endtask

  task automatic do_ack();
    ack = 1; @(negedge clk); ack = 0;
    check("R8 ack clears ready", rx_ready, 0);
    ready_m = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    wait_neg(3);
    check("R1 ready", rx_ready, 0);
    check("R1 data", rx_data, 0);
    check("R1 flags", {frame_err, par_err, overrun}, 0);
    rst_n = 1;
    wait_neg(5);

    for (int l = 0; l < 4; l++) begin
      send(8'hA5 ^ 8'(l), 2'(l), 0, 0, 1, 0, 16);
      do_ack();
    end
    send(8'h3C, 3, 1, 0, 1, 0, 16); do_ack();
    send(8'h3D, 3, 1, 1, 1, 0, 16); do_ack();
    send(8'h17, 2, 1, 0, 1, 1, 16); do_ack();
    send(8'h17, 1, 1, 1, 1, 1, 16); do_ack();
    send(8'h00, 3, 0, 0, 0, 0, 16); do_ack();

    rxd = 0; wait_neg(4); rxd = 1; wait_neg(40);
    check("R3 runt start ignored", rx_ready, 0);
    check("R3 data unchanged", rx_data, 8'h00);

    send(8'h11, 3, 0, 0, 1, 0, 16);
    send(8'h22, 3, 0, 0, 1, 0, 16);
    do_ack();

    send(8'h5A, 3, 1, 0, 1, 0, 9); do_ack();
    send(8'hC3, 3, 1, 1, 1, 0, 9); do_ack();
    send(8'h96, 3, 0, 0, 1, 0, 9);
    check("R10 back-to-back last char", rx_data, 8'h96);
    do_ack();

    for (int k = 0; k < 120; k++) begin
      logic [7:0] d;
      logic [1:0] l;
      bit pe, po, so, co;
      d = 8'($urandom); l = 2'($urandom);
      pe = 1'($urandom); po = 1'($urandom);
      so = ($urandom % 8) != 0; co = ($urandom % 4) == 0;
      send(d, l, pe, po, so, co, 9 + int'($urandom % 8));
      if ($urandom % 3 != 0) do_ack();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule